// File: doc/BRIEF.md
# Stream Link Receive Unit

This block executes a "get from stream link" operation for a small processor core. Up to sixteen AXI4-Stream slave links feed it. Each link has its own data, valid and last signals and a ready output. A decoded instruction names one link with a 4-bit index and carries five flag bits:

- non-blocking
- control (the expected value of the link's last signal)
- exception enable
- test (look without consuming)
- atomic

The block picks the link. It then finishes the operation at once or stalls the core until data arrives. When it finishes, it returns the link word for the destination register and updates a carry flag, a stream-error flag and the exception outputs.

When an instruction is issued in user mode, the block raises a privilege trap and does not touch any link. When exception reporting is enabled and a control mismatch occurs, the block raises a stream exception. That exception reports the raw link index and captures the offending word instead of writing the destination. While a blocking read stalls, the block signals whether the core may take an interrupt. This is allowed only for non-atomic reads when the extended variants are enabled.

In the default performance configuration, an operation whose data is already present completes in the cycle it is issued. The area-optimized configuration adds one evaluation cycle. Results appear on the registered outputs one cycle after the completing cycle.

Top module: `strm_get_unit`

## Requirements
- R1: A link index of NUM_LINKS or higher selects link 0. A link index below NUM_LINKS selects that link.
- R2: An operation issued with user_mode=1 completes without asserting any ready. On the next cycle it pulses exc_valid with exc_cause=5'b00111 and wr_en=0. carry, strm_err, exc_status and exc_data keep their values.
- R3: When a non-user operation completes with the selected link valid and no stream exception, wr_en pulses on the next cycle with wr_data equal to that link's data. done pulses in the cycle after every completion.
- R4: A blocking operation (nb=0) on a link whose valid is low keeps stall high and asserts no ready. It completes in the first cycle that the link's valid is high.
- R5: s_ready has at most one bit set. The set bit belongs to the selected link, is set only in the completing cycle, and is set only when that link is valid and t=0.
- R6: A non-blocking operation completes in the cycle it is evaluated. On the next cycle carry equals the inverse of the link's valid. When the link was empty there is no write. A blocking operation leaves carry unchanged.
- R7: On every non-user completion, strm_err becomes 1 exactly when the link was valid and its last bit differed from the c flag, and becomes 0 otherwise.
- R8: With e=1, a control mismatch raises exc_valid with exc_cause=5'b00000, exc_status equal to the raw instruction index, exc_data equal to the link's data, and wr_en=0.
- R9: An issue that arrives while an earlier operation is still stalled is ignored.
- R10: irq_ok is high exactly in the stall cycles of an operation with a=0.
- R11: After reset, s_ready, stall, done, wr_en, carry, strm_err and exc_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | A decoded get operation is presented |
| user_mode | input | 1 | Core is in user mode |
| op_idx | input | 4 | Link index from the instruction |
| op_nb | input | 1 | Non-blocking flag |
| op_ctl | input | 1 | Control flag, compared with the link's last bit |
| op_exc | input | 1 | Exception-enable flag |
| op_tst | input | 1 | Test flag: data is examined but not consumed |
| op_atom | input | 1 | Atomic flag: no interrupts while stalled |
| s_data | input | NUM_LINKS*DATA_W | Link data words, link i in slice i |
| s_valid | input | NUM_LINKS | Link valid bits |
| s_last | input | NUM_LINKS | Link last bits |
| s_ready | output | NUM_LINKS | Link ready bits |
| stall | output | 1 | Core must hold the operation |
| irq_ok | output | 1 | An interrupt may be taken during the stall |
| done | output | 1 | Pulse one cycle after completion |
| wr_en | output | 1 | Destination register write strobe |
| wr_data | output | DATA_W | Destination register value |
| carry | output | 1 | Carry flag (1 = no data on a non-blocking get) |
| strm_err | output | 1 | Control/data mismatch flag |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 5 | Exception cause code |
| exc_status | output | 4 | Exception-specific status (raw link index) |
| exc_data | output | DATA_W | Data captured by a stream exception |

## Verification
Two functions meet in one cycle in two places. The first is a control mismatch together with an enabled stream exception: the register write and the exception then compete for the same completion. The bench provokes this by issuing e=1 with c opposite to the link's last bit. The second is a new issue arriving in the very cycle that a stalled read finally sees valid data. The bench raises the stalled link's valid on the same edge as the extra issue. A behavioural model compares ready, stall, irq_ok and every registered output on each clock. It therefore judges that the completing operation wins, that the exception suppresses the write, and that the extra issue leaves no trace.

// File: rtl/strm_get_pkg.sv
package strm_get_pkg;

    localparam logic [4:0] CAUSE_STREAM = 5'b00000;
    localparam logic [4:0] CAUSE_PRIV   = 5'b00111;

    typedef struct packed {
        logic [3:0] idx;
        logic       nb;
        logic       ctl;
        logic       exc;
        logic       tst;
        logic       atom;
        logic       user;
    } get_op_t;

    function automatic logic [3:0] pick_link(input logic [3:0] idx, input int unsigned nl);
        return (32'(idx) >= nl) ? 4'd0 : idx;
    endfunction

endpackage

// File: rtl/strm_link_mux.sv
module strm_link_mux #(
    parameter int NUM_LINKS = 4,
    parameter int DATA_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [3:0]                    sel,
    input  logic                          take,
    input  logic [NUM_LINKS*DATA_W-1:0]   s_data,
    input  logic [NUM_LINKS-1:0]          s_valid,
    input  logic [NUM_LINKS-1:0]          s_last,
    output logic [NUM_LINKS-1:0]          s_ready,
    output logic [DATA_W-1:0]             sel_data,
    output logic                          sel_valid,
    output logic                          sel_last
);
    always_comb begin
        sel_data  = '0;
        sel_valid = 1'b0;
        sel_last  = 1'b0;
        for (int i = 0; i < NUM_LINKS; i++) begin
            if (sel == 4'(i)) begin
                sel_data  = s_data[i*DATA_W +: DATA_W];
                sel_valid = s_valid[i];
                sel_last  = s_last[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_rdy
        assign s_ready[g] = take && (sel == 4'(g));

        AST_READY_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
            s_ready[g] |-> s_valid[g]); // R5
    end
endmodule

// File: rtl/strm_get_ctrl.sv
module strm_get_ctrl
    import strm_get_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter bit AREA_OPT  = 1'b0,
    parameter bit EXT_EN    = 1'b1,
    parameter bit EXC_EN    = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    issue,
    input  get_op_t in_op,
    input  logic    sel_valid,
    output get_op_t cur,
    output logic [3:0] eff_idx,
    output logic    complete,
    output logic    take,
    output logic    stall,
    output logic    irq_ok
);
    get_op_t incoming, held;
    logic    pend, active;

    always_comb begin
        incoming = in_op;
        if (!EXT_EN) begin
            incoming.exc  = 1'b0;
            incoming.tst  = 1'b0;
            incoming.atom = 1'b0;
        end
        if (!EXC_EN) incoming.exc = 1'b0;
    end

    assign cur      = pend ? held : incoming;
    assign active   = AREA_OPT ? pend : (pend || issue);
    assign eff_idx  = pick_link(cur.idx, NUM_LINKS);
    assign complete = active && (cur.user || cur.nb || sel_valid);
    assign take     = complete && !cur.user && sel_valid && !cur.tst;
    assign stall    = (pend || issue) && !complete;
    assign irq_ok   = stall && EXT_EN && !cur.atom;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            held <= '0;
        end else if (complete) begin
            pend <= 1'b0;
        end else if (issue && !pend) begin
            pend <= 1'b1;
            held <= incoming;
        end
    end

    AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        stall |-> !take); // R4
    AST_PEND_HOLDS_OP: assert property (@(posedge clk) disable iff (rst)
        (pend && !complete) |=> (pend && $stable(held))); // R9
endmodule

// File: rtl/strm_get_status.sv
module strm_get_status
    import strm_get_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              complete,
    input  logic [3:0]        op_idx,
    input  logic              op_nb,
    input  logic              op_ctl,
    input  logic              op_exc,
    input  logic              op_user,
    input  logic              sel_valid,
    input  logic              sel_last,
    input  logic [DATA_W-1:0] sel_data,
    output logic              done,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              carry,
    output logic              strm_err,
    output logic              exc_valid,
    output logic [4:0]        exc_cause,
    output logic [3:0]        exc_status,
    output logic [DATA_W-1:0] exc_data
);
    logic mism;
    assign mism = sel_valid && (sel_last != op_ctl);

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            wr_en      <= 1'b0;
            wr_data    <= '0;
            carry      <= 1'b0;
            strm_err   <= 1'b0;
            exc_valid  <= 1'b0;
            exc_cause  <= '0;
            exc_status <= '0;
            exc_data   <= '0;
        end else begin
            done      <= complete;
            wr_en     <= 1'b0;
            exc_valid <= 1'b0;
            if (complete) begin
                if (op_user) begin
                    exc_valid <= 1'b1;
                    exc_cause <= CAUSE_PRIV;
                end else begin
                    strm_err <= mism;
                    if (op_nb) carry <= !sel_valid;
                    if (op_exc && mism) begin
                        exc_valid  <= 1'b1;
                        exc_cause  <= CAUSE_STREAM;
                        exc_status <= op_idx;
                        exc_data   <= sel_data;
                    end else if (sel_valid) begin
                        wr_en   <= 1'b1;
                        wr_data <= sel_data;
                    end
                end
            end
        end
    end

    AST_EXC_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> !wr_en); // R8
    AST_WR_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> done); // R3
endmodule

// File: rtl/strm_get_unit.sv
module strm_get_unit
    import strm_get_pkg::*;
#(
    parameter int NUM_LINKS = 4,
    parameter int DATA_W    = 32,
    parameter bit AREA_OPT  = 1'b0,
    parameter bit EXT_EN    = 1'b1,
    parameter bit EXC_EN    = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        issue,
    input  logic                        user_mode,
    input  logic [3:0]                  op_idx,
    input  logic                        op_nb,
    input  logic                        op_ctl,
    input  logic                        op_exc,
    input  logic                        op_tst,
    input  logic                        op_atom,
    input  logic [NUM_LINKS*DATA_W-1:0] s_data,
    input  logic [NUM_LINKS-1:0]        s_valid,
    input  logic [NUM_LINKS-1:0]        s_last,
    output logic [NUM_LINKS-1:0]        s_ready,
    output logic                        stall,
    output logic                        irq_ok,
    output logic                        done,
    output logic                        wr_en,
    output logic [DATA_W-1:0]           wr_data,
    output logic                        carry,
    output logic                        strm_err,
    output logic                        exc_valid,
    output logic [4:0]                  exc_cause,
    output logic [3:0]                  exc_status,
    output logic [DATA_W-1:0]           exc_data
);
    get_op_t           in_op, cur;
    logic [3:0]        eff_idx;
    logic              complete, take, sel_valid, sel_last;
    logic [DATA_W-1:0] sel_data;

    assign in_op = '{idx: op_idx, nb: op_nb, ctl: op_ctl, exc: op_exc,
                     tst: op_tst, atom: op_atom, user: user_mode};

    strm_get_ctrl #(.NUM_LINKS(NUM_LINKS), .AREA_OPT(AREA_OPT),
                    .EXT_EN(EXT_EN), .EXC_EN(EXC_EN)) i_ctrl (
        .clk(clk), .rst(rst), .issue(issue), .in_op(in_op),
        .sel_valid(sel_valid), .cur(cur), .eff_idx(eff_idx),
        .complete(complete), .take(take), .stall(stall), .irq_ok(irq_ok)
    );

    strm_link_mux #(.NUM_LINKS(NUM_LINKS), .DATA_W(DATA_W)) i_mux (
        .clk(clk), .rst(rst), .sel(eff_idx), .take(take),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .sel_data(sel_data), .sel_valid(sel_valid), .sel_last(sel_last)
    );

    strm_get_status #(.DATA_W(DATA_W)) i_status (
        .clk(clk), .rst(rst), .complete(complete),
        .op_idx(cur.idx), .op_nb(cur.nb), .op_ctl(cur.ctl), .op_exc(cur.exc),
        .op_user(cur.user), .sel_valid(sel_valid), .sel_last(sel_last),
        .sel_data(sel_data), .done(done), .wr_en(wr_en), .wr_data(wr_data),
        .carry(carry), .strm_err(strm_err), .exc_valid(exc_valid),
        .exc_cause(exc_cause), .exc_status(exc_status), .exc_data(exc_data)
    );

    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_ready)); // R5
    AST_PRIV_TRAP: assert property (@(posedge clk) disable iff (rst)
        (complete && cur.user) |=> (exc_valid && exc_cause == CAUSE_PRIV && !wr_en)); // R2
    AST_USER_NO_READY: assert property (@(posedge clk) disable iff (rst)
        (complete && cur.user) |-> (s_ready == '0)); // R2
endmodule

// File: tb/test_strm_get_unit.sv
module test_strm_get_unit;
    localparam int NL = 4;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic issue = 1'b0, user_mode = 1'b0;
    logic [3:0] op_idx = '0;
    logic op_nb = 0, op_ctl = 0, op_exc = 0, op_tst = 0, op_atom = 0;
    logic [DW-1:0] ldata [NL];
    logic [NL*DW-1:0] s_data;
    logic [NL-1:0] s_valid = '0, s_last = '0, s_ready;
    logic stall, irq_ok, done, wr_en, carry, strm_err, exc_valid;
    logic [DW-1:0] wr_data, exc_data;
    logic [4:0] exc_cause;
    logic [3:0] exc_status;

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    always_comb for (int i = 0; i < NL; i++) s_data[i*DW +: DW] = ldata[i];

    strm_get_unit #(.NUM_LINKS(NL), .DATA_W(DW)) i_strm_get_unit (
        .clk(clk), .rst(rst), .issue(issue), .user_mode(user_mode),
        .op_idx(op_idx), .op_nb(op_nb), .op_ctl(op_ctl), .op_exc(op_exc),
        .op_tst(op_tst), .op_atom(op_atom), .s_data(s_data), .s_valid(s_valid),
        .s_last(s_last), .s_ready(s_ready), .stall(stall), .irq_ok(irq_ok),
        .done(done), .wr_en(wr_en), .wr_data(wr_data), .carry(carry),
        .strm_err(strm_err), .exc_valid(exc_valid), .exc_cause(exc_cause),
        .exc_status(exc_status), .exc_data(exc_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference model state
    bit m_pend;
    int h_idx; bit h_nb, h_c, h_e, h_t, h_a, h_u;
    bit e_done, e_wr, e_carry, e_serr, e_exc;
    int e_wd, e_cause, e_stat, e_data;

    always @(posedge clk) begin : model
        int idx, eff; bit nb, c, e, t, a, u, act, v, lst, comp, mism;
        int exp_rdy, d;
        cycles++;
        if (rst) begin
            m_pend <= 0; e_done <= 0; e_wr <= 0; e_carry <= 0; e_serr <= 0;
            e_exc <= 0; e_wd <= 0; e_cause <= 0; e_stat <= 0; e_data <= 0;
        end else begin
            if (m_pend) begin
                idx = h_idx; nb = h_nb; c = h_c; e = h_e; t = h_t; a = h_a; u = h_u;
            end else begin
                idx = int'(op_idx); nb = op_nb; c = op_ctl; e = op_exc;
                t = op_tst; a = op_atom; u = user_mode;
            end
            act  = m_pend || issue;
            eff  = (idx >= NL) ? 0 : idx;              // R1
            v    = s_valid[eff];
            lst  = s_last[eff];
            d    = int'(ldata[eff]);
            comp = act && (u || nb || v);
            mism = v && (lst != c);
            exp_rdy = (comp && !u && v && !t) ? (1 << eff) : 0;
            chk(int'(s_ready) == exp_rdy, "R1,R5,R2 s_ready", s_ready, exp_rdy);
            chk(stall == (act && !comp), "R4,R9 stall", stall, act && !comp);
            chk(irq_ok == (act && !comp && !a), "R10 irq_ok", irq_ok, act && !comp && !a);
            chk(done == e_done, "R3 done", done, e_done);
            chk(wr_en == e_wr, "R3 wr_en", wr_en, e_wr);
            if (e_wr) chk(int'(wr_data) == e_wd, "R3 wr_data", wr_data, e_wd);
            chk(carry == e_carry, "R6 carry", carry, e_carry);
            chk(strm_err == e_serr, "R7 strm_err", strm_err, e_serr);
            chk(exc_valid == e_exc, "R8,R2 exc_valid", exc_valid, e_exc);
            chk(int'(exc_cause) == e_cause, "R8,R2 exc_cause", exc_cause, e_cause);
            chk(int'(exc_status) == e_stat, "R8 exc_status", exc_status, e_stat);
            chk(int'(exc_data) == e_data, "R8 exc_data", exc_data, e_data);
            // next state
            e_done <= comp; e_wr <= 0; e_exc <= 0;
            if (comp) begin
                m_pend <= 0;
                if (u) begin
                    e_exc <= 1; e_cause <= 7;
                end else begin
                    e_serr <= mism;
                    if (nb) e_carry <= !v;
                    if (e && mism) begin
                        e_exc <= 1; e_cause <= 0; e_stat <= idx; e_data <= d;
                    end else if (v) begin
                        e_wr <= 1; e_wd <= d;
                    end
                end
            end else if (issue && !m_pend) begin
                m_pend <= 1;
                h_idx <= int'(op_idx); h_nb <= op_nb; h_c <= op_ctl; h_e <= op_exc;
                h_t <= op_tst; h_a <= op_atom; h_u <= user_mode;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_op(input int idx, input bit nb, c, e, t, a, u);
        @(negedge clk);
        issue = 1; op_idx = 4'(idx); op_nb = nb; op_ctl = c; op_exc = e;
        op_tst = t; op_atom = a; user_mode = u;
        @(negedge clk);
        issue = 0; op_nb = 0; op_ctl = 0; op_exc = 0; op_tst = 0; op_atom = 0; user_mode = 0;
    endtask

    initial begin
        for (int i = 0; i < NL; i++) ldata[i] = 32'hC0DE_0000 + 32'(i * 17);
        idle(3);
        // R11 reset state
        chk(s_ready == 0, "R11 s_ready", s_ready, 0);
        chk(stall == 0, "R11 stall", stall, 0);
        chk(done == 0 && wr_en == 0, "R11 done/wr_en", {done, wr_en}, 0);
        chk(carry == 0 && strm_err == 0 && exc_valid == 0, "R11 flags",
            {carry, strm_err, exc_valid}, 0);
        rst = 0;
        idle(2);
        // R3 blocking get, data present
        s_valid = 4'b0100; do_op(2, 0, 0, 0, 0, 0, 0); idle(2);
        // R6 non-blocking get on empty link
        s_valid = 4'b0000; do_op(1, 1, 0, 0, 0, 0, 0); idle(2);
        // R6 non-blocking get with data
        s_valid = 4'b0010; ldata[1] = 32'h1234_5678; do_op(1, 1, 0, 0, 0, 0, 0); idle(2);
        // R4/R9/R10 stall, extra issue ignored, valid arrives with another issue
        s_valid = 4'b0000; do_op(3, 0, 0, 0, 0, 0, 0); idle(2);
        do_op(2, 1, 0, 0, 0, 0, 0);
        @(negedge clk); s_valid = 4'b1000; issue = 1; op_idx = 4'd0; op_nb = 1;
        @(negedge clk); issue = 0; op_nb = 0; s_valid = 4'b0000; idle(2);
        // R1 out-of-range index maps to link 0
        s_valid = 4'b0001; ldata[0] = 32'hAAAA_5555; do_op(9, 0, 0, 0, 0, 0, 0); idle(2);
        // R7 mismatch without exception
        s_valid = 4'b0100; s_last = 4'b0100; do_op(2, 0, 0, 0, 0, 0, 0); idle(2);
        // R8 mismatch with exception, raw index 6 -> link 0
        s_valid = 4'b0001; s_last = 4'b0000; ldata[0] = 32'h0BAD_F00D;
        do_op(6, 0, 1, 1, 0, 0, 0); idle(2);
        // R7 matching control, e=1 -> no exception
        s_valid = 4'b0001; s_last = 4'b0001; do_op(0, 0, 1, 1, 0, 0, 0); idle(2);
        // R5 test mode: no ready
        s_valid = 4'b1111; s_last = 4'b0000; do_op(3, 0, 0, 0, 1, 0, 0); idle(2);
        // R2 user mode trap
        do_op(1, 0, 0, 0, 0, 0, 1); idle(2);
        // R10 atomic blocking stall
        s_valid = 4'b0000; do_op(2, 0, 0, 0, 0, 1, 0); idle(3);
        s_valid = 4'b0100; @(negedge clk); s_valid = 4'b0000; idle(3);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule